// File: doc/BRIEF.md
# Row Centroid Steering Estimator

This block takes a binary trail mask, one pixel per accepted beat in raster order, and turns each frame into one signed steering offset. It follows a fixed set of sampled rows in the lower half of the image. On each of those rows it adds up the column positions of the white (trail) pixels and counts them. When the last pixel of the frame arrives, a control sequencer runs one shared sequential divider several times. It first finds the trail centre of every sampled row that has trail pixels. It then finds the weighted mean of those centres, using a programmable weight per row. The offset of that mean from the image centre is the result.

The result is a register that holds the offset, a no-trail flag and a valid flag. A one-cycle done pulse marks each new result, which software or a steering stage reads after the pulse. While the block computes, it raises busy and ignores the pixel stream. The image position is counted inside the block, so the source must hold pixels back while busy is high.

Top module: `row_steer_top`

## Requirements
- R1: After reset, resultValid, done, busy and noTrail are 0, steerOffset is 0, and every weight table entry holds 1.
- R2: A pixel is accepted on a clock edge where pixValid is 1 and busy is 0. Accepted pixels fill columns 0 to IMG_W-1 of each line and lines 0 to IMG_H-1 of each frame, in that order. pixWhite=1 marks a trail pixel.
- R3: There are NUM_ROWS sampled rows. Sampled row k is line IMG_H/2 + (k*(IMG_H/2))/NUM_ROWS. White pixels on any other line have no effect on the result.
- R4: A sampled row's centre is floor(sum of white column indices / number of white pixels) on that row.
- R5: steerOffset = floor(sum of w_k*centre_k / sum of w_k) - IMG_W/2. Both sums run over the sampled rows that hold at least one white pixel. The value is signed two's complement.
- R6: A sampled row with no white pixels adds nothing to either sum, whatever its weight.
- R7: If no sampled row has a white pixel, or the contributing weights sum to zero, steerOffset is 0 and noTrail is 1. Otherwise noTrail is 0.
- R8: When wgtWe is 1 on a clock edge, wgtData is written to weight entry wgtIdx (entry k belongs to sampled row k). The new weight is used by every later computation.
- R9: busy is 1 from the edge that accepts the last pixel of a frame until the result is written. done is 1 for exactly one cycle, and in that same cycle steerOffset, noTrail and resultValid=1 become visible. resultValid stays 1 until the first pixel of the next frame is accepted.
- R10: Pixels presented while busy is 1 are ignored: they advance no position and change no row sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Mask pixel present |
| pixWhite | input | 1 | Mask pixel is trail |
| wgtWe | input | 1 | Weight table write enable |
| wgtIdx | input | $clog2(NUM_ROWS) | Weight entry to write |
| wgtData | input | WGT_W | Weight value |
| busy | output | 1 | Computing; stream not accepted |
| steerOffset | output | $clog2(IMG_W)+1 | Signed offset of weighted centre from image centre |
| noTrail | output | 1 | No usable trail in the last frame |
| resultValid | output | 1 | Result registers hold a current frame's result |
| done | output | 1 | One-cycle pulse when a result is written |

## Verification
Some rules are checked by assertions on every cycle. Every quotient equals the exact floor division of its operands, with a remainder below the divisor. A centre never exceeds the image width. A no-trail result always reads zero. done never lasts two cycles and always comes with resultValid. The pixel position never moves while busy. Other behaviour needs whole frames and can only be shown by the bench scenarios: which lines are sampled, the truncating arithmetic, leaving out empty rows, the effect of a weight write, and that a stream presented while busy leaves the next frame's result unshifted.

// File: rtl/row_steer_pkg.sv
package row_steer_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic divStart;   // load divider with selected operands
    logic divFinal;   // operands are accumulator / weight total
    logic rowLatch;   // fold current row centre into accumulators
    logic finLatch;   // write final offset to result
    logic emptyLatch; // write no-trail result
  } steer_strobe_t;
endpackage

// File: rtl/row_steer_div.sv
module row_steer_div #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [DIVW-1:0] num,
  input  logic [DIVW-1:0] den,
  output logic [DIVW-1:0] quo,
  output logic            divDone
);
  localparam int CNTW = $clog2(DIVW + 1);

  logic [DIVW-1:0] rem, denReg, numReg;
  logic [CNTW-1:0] steps;
  logic [DIVW:0]   remShift;

  assign remShift = {rem, quo[DIVW-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem <= '0; quo <= '0; denReg <= '0; numReg <= '0;
      steps <= '0; divDone <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (start) begin
        rem <= '0; quo <= num; denReg <= den; numReg <= num;
        steps <= CNTW'(DIVW);
      end else if (steps != '0) begin
        if (remShift >= {1'b0, denReg}) begin
          rem <= DIVW'(remShift - {1'b0, denReg});
          quo <= {quo[DIVW-2:0], 1'b1};
        end else begin
          rem <= remShift[DIVW-1:0];
          quo <= {quo[DIVW-2:0], 1'b0};
        end
        steps <= steps - 1'b1;
        if (steps == CNTW'(1)) divDone <= 1'b1;
      end
    end
  end

  // R4 / R5: every quotient is an exact floor division
  a_r4_div_exact: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> ((2*DIVW)'(quo) * (2*DIVW)'(denReg) + (2*DIVW)'(rem)
                 == (2*DIVW)'(numReg)) && (rem < denReg));
endmodule

// File: rtl/row_steer_ctrl.sv
module row_steer_ctrl
  import row_steer_pkg::*;
#(
  parameter int NUM_ROWS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameEnd,
  input  logic                        rowEmpty,
  input  logic                        wsumZero,
  input  logic                        divDone,
  output steer_strobe_t               stb,
  output logic [$clog2(NUM_ROWS)-1:0] rowIdx,
  output logic                        busy
);
  localparam int RIW = $clog2(NUM_ROWS);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_ROW_WAIT, S_FIN, S_FIN_WAIT} state_t;
  state_t state, stateNext;
  logic   lastRow;

  assign lastRow = (rowIdx == RIW'(NUM_ROWS - 1));
  assign busy    = (state != S_IDLE);

  always_comb begin
    stateNext = state;
    stb = '0;
    unique case (state)
      S_IDLE:     if (frameEnd) stateNext = S_ROW;
      S_ROW:
        if (rowEmpty) stateNext = lastRow ? S_FIN : S_ROW;
        else begin stb.divStart = 1'b1; stateNext = S_ROW_WAIT; end
      S_ROW_WAIT:
        if (divDone) begin
          stb.rowLatch = 1'b1;
          stateNext = lastRow ? S_FIN : S_ROW;
        end
      S_FIN:
        if (wsumZero) begin stb.emptyLatch = 1'b1; stateNext = S_IDLE; end
        else begin
          stb.divStart = 1'b1; stb.divFinal = 1'b1; stateNext = S_FIN_WAIT;
        end
      S_FIN_WAIT:
        if (divDone) begin stb.finLatch = 1'b1; stateNext = S_IDLE; end
      default:    stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; rowIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE) rowIdx <= '0;
      else if (((state == S_ROW && rowEmpty) || (state == S_ROW_WAIT && divDone))
               && !lastRow)
        rowIdx <= rowIdx + 1'b1;
    end
  end

  // R9: a result is written only by leaving the busy state
  a_r9_result_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finLatch || stb.emptyLatch) |=> !busy);
endmodule

// File: rtl/row_steer_dp.sv
module row_steer_dp
  import row_steer_pkg::*;
#(
  parameter int IMG_W    = 16,
  parameter int IMG_H    = 32,
  parameter int NUM_ROWS = 8,
  parameter int WGT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pixValid,
  input  logic                        pixWhite,
  input  logic                        wgtWe,
  input  logic [$clog2(NUM_ROWS)-1:0] wgtIdx,
  input  logic [WGT_W-1:0]            wgtData,
  input  logic                        busy,
  input  steer_strobe_t               stb,
  input  logic [$clog2(NUM_ROWS)-1:0] rowIdx,
  output logic                        frameEnd,
  output logic                        rowEmpty,
  output logic                        wsumZero,
  output logic                        divDone,
  output logic signed [$clog2(IMG_W):0] steerOffset,
  output logic                        noTrail,
  output logic                        resultValid,
  output logic                        done
);
  localparam int XW   = $clog2(IMG_W);
  localparam int YW   = $clog2(IMG_H);
  localparam int CW   = $clog2(IMG_W + 1);
  localparam int SW   = XW + CW;
  localparam int TW   = WGT_W + $clog2(NUM_ROWS + 1);
  localparam int ACCW = XW + TW;
  localparam int DIVW = (SW > ACCW) ? SW : ACCW;
  localparam int OW   = XW + 1;
  localparam logic signed [OW-1:0] HALF = OW'(IMG_W / 2);

  logic [XW-1:0]    xCnt;
  logic [YW-1:0]    yCnt;
  logic             accept, frameStart, clearAll;
  logic [NUM_ROWS-1:0] rowHit;
  logic [SW-1:0]    rowSum [NUM_ROWS];
  logic [CW-1:0]    rowCnt [NUM_ROWS];
  logic [WGT_W-1:0] wgt    [NUM_ROWS];
  logic [ACCW-1:0]  acc;
  logic [TW-1:0]    wsum;
  logic [DIVW-1:0]  divNum, divDen, quo;
  logic [XW-1:0]    quoX;

  assign accept     = pixValid && !busy;
  assign frameStart = accept && xCnt == '0 && yCnt == '0;
  assign frameEnd   = accept && xCnt == XW'(IMG_W - 1) && yCnt == YW'(IMG_H - 1);
  assign clearAll   = stb.finLatch || stb.emptyLatch;
  assign rowEmpty   = (rowCnt[rowIdx] == '0);
  assign wsumZero   = (wsum == '0);
  assign quoX       = quo[XW-1:0];

  // Sampled-row decode, one comparator per row
  for (genvar k = 0; k < NUM_ROWS; k++) begin : g_rowsel
    localparam int ROW_Y = IMG_H/2 + (k * (IMG_H/2)) / NUM_ROWS;
    assign rowHit[k] = accept && pixWhite && (yCnt == YW'(ROW_Y));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xCnt <= '0; yCnt <= '0;
    end else if (accept) begin
      if (xCnt == XW'(IMG_W - 1)) begin
        xCnt <= '0;
        yCnt <= (yCnt == YW'(IMG_H - 1)) ? '0 : yCnt + 1'b1;
      end else xCnt <= xCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_ROWS; k++) begin
      if (!rstN || clearAll) begin
        rowSum[k] <= '0; rowCnt[k] <= '0;
      end else if (rowHit[k]) begin
        rowSum[k] <= rowSum[k] + SW'(xCnt);
        rowCnt[k] <= rowCnt[k] + 1'b1;
      end
      if (!rstN) wgt[k] <= WGT_W'(1);
      else if (wgtWe && wgtIdx == $clog2(NUM_ROWS)'(k)) wgt[k] <= wgtData;
    end
  end

  assign divNum = stb.divFinal ? DIVW'(acc)  : DIVW'(rowSum[rowIdx]);
  assign divDen = stb.divFinal ? DIVW'(wsum) : DIVW'(rowCnt[rowIdx]);

  row_steer_div #(.DIVW(DIVW)) div_i (
    .clk(clk), .rstN(rstN), .start(stb.divStart),
    .num(divNum), .den(divDen), .quo(quo), .divDone(divDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN || clearAll) begin
      acc <= '0; wsum <= '0;
    end else if (stb.rowLatch) begin
      acc  <= acc + ACCW'(wgt[rowIdx]) * ACCW'(quoX);
      wsum <= wsum + TW'(wgt[rowIdx]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      steerOffset <= '0; noTrail <= 1'b0; resultValid <= 1'b0; done <= 1'b0;
    end else begin
      done <= clearAll;
      if (stb.finLatch) begin
        steerOffset <= $signed({1'b0, quoX}) - HALF;
        noTrail <= 1'b0; resultValid <= 1'b1;
      end else if (stb.emptyLatch) begin
        steerOffset <= '0; noTrail <= 1'b1; resultValid <= 1'b1;
      end else if (frameStart) resultValid <= 1'b0;
    end
  end

  // R4: a centre or weighted mean never reaches the image width
  a_r4_quot_range: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> quo < DIVW'(IMG_W));
  // R7: a no-trail result reads zero
  a_r7_notrail_zero: assert property (@(posedge clk) disable iff (!rstN)
    noTrail |-> steerOffset == '0);
  // R9: done is a single-cycle pulse that comes with a valid result
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_valid: assert property (@(posedge clk) disable iff (!rstN)
    done |-> resultValid);
  // R10: position frozen while computing
  a_r10_hold_pos: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(xCnt) && $stable(yCnt));
  // R5: offset lies inside the image half-width range
  a_r5_range: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (steerOffset >= -HALF) && (steerOffset < HALF));
endmodule

// File: rtl/row_steer_top.sv
module row_steer_top
  import row_steer_pkg::*;
#(
  parameter int IMG_W    = 1280,
  parameter int IMG_H    = 720,
  parameter int NUM_ROWS = 8,
  parameter int WGT_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pixValid,
  input  logic                          pixWhite,
  input  logic                          wgtWe,
  input  logic [$clog2(NUM_ROWS)-1:0]   wgtIdx,
  input  logic [WGT_W-1:0]              wgtData,
  output logic                          busy,
  output logic signed [$clog2(IMG_W):0] steerOffset,
  output logic                          noTrail,
  output logic                          resultValid,
  output logic                          done
);
  steer_strobe_t stb;
  logic [$clog2(NUM_ROWS)-1:0] rowIdx;
  logic frameEnd, rowEmpty, wsumZero, divDone;

  row_steer_ctrl #(.NUM_ROWS(NUM_ROWS)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .rowEmpty(rowEmpty),
    .wsumZero(wsumZero), .divDone(divDone), .stb(stb), .rowIdx(rowIdx),
    .busy(busy)
  );

  row_steer_dp #(.IMG_W(IMG_W), .IMG_H(IMG_H), .NUM_ROWS(NUM_ROWS),
                 .WGT_W(WGT_W)) dp_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixWhite(pixWhite),
    .wgtWe(wgtWe), .wgtIdx(wgtIdx), .wgtData(wgtData), .busy(busy),
    .stb(stb), .rowIdx(rowIdx), .frameEnd(frameEnd), .rowEmpty(rowEmpty),
    .wsumZero(wsumZero), .divDone(divDone), .steerOffset(steerOffset),
    .noTrail(noTrail), .resultValid(resultValid), .done(done)
  );
endmodule

// File: tb/row_steer_top_tb_top.sv
module row_steer_top_tb_top;
  localparam int W = 16, H = 32, N = 8, WW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic pixValid = 1'b0, pixWhite = 1'b0, wgtWe = 1'b0;
  logic [$clog2(N)-1:0] wgtIdx = '0;
  logic [WW-1:0] wgtData = '0;
  logic busy, noTrail, resultValid, done;
  logic signed [$clog2(W):0] steerOffset;

  int checks = 0, fails = 0;
  logic [W-1:0] mask [H];
  int wts [N];

  always #2ns clk = ~clk;

  row_steer_top #(.IMG_W(W), .IMG_H(H), .NUM_ROWS(N), .WGT_W(WW)) dut_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixWhite(pixWhite),
    .wgtWe(wgtWe), .wgtIdx(wgtIdx), .wgtData(wgtData), .busy(busy),
    .steerOffset(steerOffset), .noTrail(noTrail), .resultValid(resultValid),
    .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rowY(input int k);
    return H/2 + (k * (H/2)) / N;
  endfunction

  task automatic model(output int off, output int nt);
    longint acc = 0, ws = 0;
    for (int k = 0; k < N; k++) begin
      int s = 0, c = 0;
      for (int x = 0; x < W; x++) if (mask[rowY(k)][x]) begin s += x; c++; end
      if (c > 0) begin acc += wts[k] * (s / c); ws += wts[k]; end
    end
    if (ws == 0) begin off = 0; nt = 1; end
    else begin off = int'(acc / ws) - W/2; nt = 0; end
  endtask

  task automatic clearMask();
    for (int y = 0; y < H; y++) mask[y] = '0;
  endtask

  task automatic setRow(input int k, input int lo, input int hi);
    for (int x = lo; x <= hi; x++) mask[rowY(k)][x] = 1'b1;
  endtask

  task automatic writeWgt(input int k, input int v);
    @(negedge clk); wgtWe = 1'b1; wgtIdx = k[$clog2(N)-1:0]; wgtData = v[WW-1:0];
    @(negedge clk); wgtWe = 1'b0;
    wts[k] = v;
  endtask

  // Streams one frame; leaves clock at the negedge after the last accept.
  task automatic sendFrame(input bit garbage);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        if (y == 0 && x == 1) check("R9 valid cleared by new frame", resultValid, 0);
        pixValid = 1'b1; pixWhite = mask[y][x];
      end
    @(negedge clk);
    check("R9 busy after last pixel", busy, 1);
    if (garbage) begin
      for (int i = 0; i < 40; i++) begin
        pixWhite = i[0];
        @(negedge clk);
      end
    end
    pixValid = 1'b0; pixWhite = 1'b0;
  endtask

  task automatic runAndCheck(input string req);
    int off, nt, seen = 0;
    model(off, nt);
    for (int i = 0; i < 3000 && seen == 0; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    check({req, " done seen"}, seen, 1);
    check({req, " offset"}, int'(steerOffset), off);
    check({req, " noTrail"}, int'(noTrail), nt);
    check({req, " valid with done"}, int'(resultValid), 1);
    @(negedge clk);
    check("R9 done single cycle", int'(done), 0);
    check("R9 valid held", int'(resultValid), 1);
    check("R9 busy cleared", int'(busy), 0);
  endtask

  task automatic testReset();
    check("R1 resultValid", resultValid, 0);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 noTrail", noTrail, 0);
    check("R1 offset", int'(steerOffset), 0);
  endtask

  task automatic testCentreWithClutter();
    clearMask();
    for (int y = 0; y < H; y++) mask[y][3:0] = 4'hF; // clutter on all lines
    for (int k = 0; k < N; k++) begin
      for (int x = 0; x < 4; x++) mask[rowY(k)][x] = 1'b0;
      setRow(k, 10, 12);
    end
    sendFrame(0);
    runAndCheck("R3 R5 unsampled lines ignored, uniform weights");
    check("R3 expected +3", int'(steerOffset), 3);
  endtask

  task automatic testTruncation();
    clearMask();
    for (int k = 0; k < N; k++) setRow(k, 1, 4);
    sendFrame(0);
    runAndCheck("R4 truncating centre");
    check("R4 expected -6", int'(steerOffset), -6);
  endtask

  task automatic testWeightedMixed();
    for (int k = 0; k < N; k++) writeWgt(k, k + 1);
    clearMask();
    setRow(0, 2, 5); setRow(2, 15, 15); setRow(3, 0, 15);
    setRow(5, 9, 10); setRow(6, 4, 4); setRow(6, 12, 12); setRow(7, 13, 14);
    sendFrame(0);
    runAndCheck("R5 R6 R8 weighted, empty rows skipped");
    // rows 1 and 4 carry weight but no pixels: a heavy weight there changes nothing
    writeWgt(1, 200); writeWgt(4, 200);
    sendFrame(0);
    runAndCheck("R6 weight on empty rows has no effect");
    // weight write alters the result when the row has pixels
    writeWgt(2, 200);
    sendFrame(0);
    runAndCheck("R8 new weight applied");
  endtask

  task automatic testNoTrail();
    clearMask();
    for (int y = 0; y < H; y++) mask[y] = '1;
    for (int k = 0; k < N; k++) mask[rowY(k)] = '0;
    sendFrame(0);
    runAndCheck("R7 no sampled trail");
    check("R7 noTrail set", int'(noTrail), 1);
    // zero weights on the only populated rows
    clearMask();
    setRow(3, 5, 9); setRow(5, 0, 2);
    writeWgt(3, 0); writeWgt(5, 0);
    sendFrame(0);
    runAndCheck("R7 zero weight total");
    check("R7 zero weight noTrail", int'(noTrail), 1);
    for (int k = 0; k < N; k++) writeWgt(k, 1);
  endtask

  task automatic testBusyIgnore();
    clearMask();
    for (int k = 0; k < N; k++) setRow(k, 6 + k, 8 + k);
    sendFrame(1);
    runAndCheck("R10 frame with stream during busy");
    clearMask();
    for (int k = 0; k < N; k++) setRow(k, 12, 14);
    sendFrame(0);
    runAndCheck("R2 R10 next frame aligned");
    check("R10 expected +5", int'(steerOffset), 5);
  endtask

  initial begin
    for (int k = 0; k < N; k++) wts[k] = 1;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCentreWithClutter();
    testTruncation();
    testWeightedMixed();
    testNoTrail();
    testBusyIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule